// File: doc/BRIEF.md
# Hypercube Dimension-Ordered Router Node

This block is one switching node of a binary hypercube of 2^DIM processors. Each node has a DIM-bit label on `node_id` and one bidirectional link per dimension. Link `d` goes to the neighbour whose label differs from this node's label in bit `d` only. The node has four kinds of stream port: a local injection port, DIM incoming links, DIM outgoing links and a local ejection port. All of them are valid/ready streams that carry one-word packets. The low DIM bits of a packet are its destination label, and the PAY_W bits above them are the payload, which passes through unchanged.

The next hop is chosen by fixed dimension order. The node XORs the destination with its own label and takes the most significant set bit of the result. The packet leaves on the link of that dimension. When the XOR is zero, the packet goes to the ejection port. Because every node corrects the highest differing bit first, routes never form a cycle of buffer dependencies. Full buffers therefore stall traffic for a while but cannot deadlock it. A packet needs at most DIM hops.

Each output owns a one-entry slot. A round-robin arbiter per output picks one requesting input in any cycle where that slot is empty. Back-pressure rules:
- An input's ready is high only in the cycle its packet is moved into a slot.
- A slot holds its packet, with valid high and data steady, until its consumer raises ready.
- A packet is never dropped.

Top module: `hcube_router`

## Requirements
- R1: After reset, no outgoing link and no ejection port shows valid, and no input is accepted before one is presented.
- R2: A packet whose low DIM bits equal `node_id` leaves on the ejection port.
- R3: Any other packet leaves on outgoing link d, where d is the index of the most significant set bit of (destination XOR `node_id`). Link d reaches the node whose label differs in bit d alone.
- R4: Across the network each hop flips the leftmost remaining differing bit. A packet makes exactly popcount(source XOR destination) hops, never more than DIM.
- R5: In a 3-cube, a packet from node 000 to node 101 passes through node 100 and through no other intermediate node.
- R6: While an output's ready is low, its valid stays high and its data stays unchanged. The packet is never lost.
- R7: Each output holds at most one packet. An input's ready goes high only in a cycle where the slot of its target output is empty and the input wins that slot.
- R8: Inputs are indexed with links 0..DIM-1 first and the local injection at index DIM. Each output arbiter grants the first requester found after the previous winner, in rising index order with wrap-around. A losing input keeps valid high and its packet unchanged.
- R9: The payload bits (above the low DIM bits) arrive at the destination unchanged.
- R10: When every node injects one packet to every destination at once, each of those packets is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | DIM | This node's label |
| inj_valid | input | 1 | Local injection packet present |
| inj_ready | output | 1 | Local injection packet taken this cycle |
| inj_data | input | PAY_W+DIM | Local injection packet |
| lnk_in_valid | input | DIM | Per-dimension incoming packet present |
| lnk_in_ready | output | DIM | Per-dimension incoming packet taken |
| lnk_in_data | input | DIM*(PAY_W+DIM) | Incoming packets, dimension d in slice d |
| lnk_out_valid | output | DIM | Per-dimension outgoing packet present |
| lnk_out_ready | input | DIM | Per-dimension neighbour can take the packet |
| lnk_out_data | output | DIM*(PAY_W+DIM) | Outgoing packets, dimension d in slice d |
| ej_valid | output | 1 | Packet for this node present |
| ej_ready | input | 1 | Local consumer takes the packet |
| ej_data | output | PAY_W+DIM | Packet for this node |

## Verification
Eight nodes are wired into a 3-cube. Every one of the 64 source/destination pairs is sent alone, so each hop can be compared with the leftmost-bit rule and each hop count with the popcount of source XOR destination. The pair 000 to 101 shows whether the order is really most-significant-first, because a least-significant-first router would go through 001 instead. Holding one ejection port low exposes any slot that overwrites or drops a packet. A three-way contention at one node, set up with the arbiter pointer in a known position, separates round-robin granting from fixed lowest-index priority. An all-to-all burst shows whether dimension ordering keeps the one-entry slots from locking up.

// File: rtl/hc_pkg.sv
package hc_pkg;
  // Index of the highest set bit, or -1 when the vector is zero.
  function automatic int hc_lead_one(input logic [31:0] v);
    int r;
    r = -1;
    for (int b = 0; b < 32; b++) begin
      if (v[b]) r = b;
    end
    return r;
  endfunction
endpackage

// File: rtl/hc_route.sv
module hc_route
  import hc_pkg::*;
#(
  parameter int DIM = 3
) (
  input  logic [DIM-1:0] node_id,
  input  logic [DIM-1:0] dest,
  output logic [DIM:0]   req
);
  logic [DIM-1:0] diff;
  int             lead;

  assign diff = dest ^ node_id;
  assign lead = hc_lead_one(32'(diff));

  // One request bit per link dimension, top bit for local ejection.
  always_comb begin
    for (int b = 0; b < DIM; b++) req[b] = (lead == b);
    req[DIM] = (diff == '0);
  end
endmodule

// File: rtl/hc_rr_arb.sv
module hc_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last;
  logic [IW-1:0] pick;
  logic          hit;

  // Search starts one past the previous winner and wraps around.
  always_comb begin
    gnt  = '0;
    hit  = 1'b0;
    pick = last;
    for (int off = 1; off <= N; off++) begin
      int t;
      t = int'(last) + off;
      if (t >= N) t = t - N;
      if (!hit && en && req[t]) begin
        hit    = 1'b1;
        gnt[t] = 1'b1;
        pick   = IW'(t);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last <= IW'(N - 1);
    else if (hit) last <= pick;
  end

  // R8
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R8
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  // R7
  gnt_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> en);
endmodule

// File: rtl/hc_out_slot.sv
module hc_out_slot #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         o_valid,
  input  logic         o_ready,
  output logic [W-1:0] o_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
    end else if (load) begin
      o_valid <= 1'b1;
      o_data  <= din;
    end else if (o_valid && o_ready) begin
      o_valid <= 1'b0;
    end
  end

  // R7
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !o_valid);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));
endmodule

// File: rtl/hcube_router.sv
module hcube_router
  import hc_pkg::*;
#(
  parameter int DIM   = 3,
  parameter int PAY_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DIM-1:0]               node_id,
  input  logic                         inj_valid,
  output logic                         inj_ready,
  input  logic [PAY_W+DIM-1:0]         inj_data,
  input  logic [DIM-1:0]               lnk_in_valid,
  output logic [DIM-1:0]               lnk_in_ready,
  input  logic [DIM*(PAY_W+DIM)-1:0]   lnk_in_data,
  output logic [DIM-1:0]               lnk_out_valid,
  input  logic [DIM-1:0]               lnk_out_ready,
  output logic [DIM*(PAY_W+DIM)-1:0]   lnk_out_data,
  output logic                         ej_valid,
  input  logic                         ej_ready,
  output logic [PAY_W+DIM-1:0]         ej_data
);
  localparam int PKT_W = PAY_W + DIM;
  localparam int NP    = DIM + 1;   // ports: links 0..DIM-1, local at DIM

  logic [NP-1:0]    in_v, in_rdy, o_v, o_r, load;
  logic [PKT_W-1:0] in_pkt  [NP];
  logic [PKT_W-1:0] o_pkt   [NP];
  logic [PKT_W-1:0] win_pkt [NP];
  logic [NP-1:0]    want    [NP];   // want[input][output]
  logic [NP-1:0]    bid     [NP];   // bid[output][input]
  logic [NP-1:0]    gnt     [NP];   // gnt[output][input]

  assign in_v         = {inj_valid, lnk_in_valid};
  assign o_r          = {ej_ready, lnk_out_ready};
  assign inj_ready    = in_rdy[DIM];
  assign lnk_in_ready = in_rdy[DIM-1:0];
  assign lnk_out_valid = o_v[DIM-1:0];
  assign ej_valid     = o_v[DIM];
  assign ej_data      = o_pkt[DIM];

  genvar i, o;
  generate
    for (i = 0; i < NP; i++) begin : g_in
      if (i < DIM) begin : g_lnk
        assign in_pkt[i] = lnk_in_data[i*PKT_W +: PKT_W];
      end else begin : g_loc
        assign in_pkt[i] = inj_data;
      end
      hc_route #(.DIM(DIM)) u_route (
        .node_id (node_id),
        .dest    (in_pkt[i][DIM-1:0]),
        .req     (want[i])
      );
    end

    for (o = 0; o < NP; o++) begin : g_out
      for (i = 0; i < NP; i++) begin : g_bid
        assign bid[o][i] = in_v[i] & want[i][o];
      end

      hc_rr_arb #(.N(NP)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (!o_v[o]),
        .req   (bid[o]),
        .gnt   (gnt[o])
      );

      always_comb begin
        win_pkt[o] = '0;
        for (int k = 0; k < NP; k++) begin
          if (gnt[o][k]) win_pkt[o] = win_pkt[o] | in_pkt[k];
        end
      end

      assign load[o] = |gnt[o];

      hc_out_slot #(.W(PKT_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load[o]),
        .din     (win_pkt[o]),
        .o_valid (o_v[o]),
        .o_ready (o_r[o]),
        .o_data  (o_pkt[o])
      );

      if (o < DIM) begin : g_lnk_out
        assign lnk_out_data[o*PKT_W +: PKT_W] = o_pkt[o];

        // R3
        fwd_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
          lnk_out_valid[o] |->
            (((lnk_out_data[o*PKT_W +: DIM] ^ node_id) >> o) == DIM'(1)));
        // R4
        arrive_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
          lnk_in_valid[o] |->
            (((lnk_in_data[o*PKT_W +: DIM] ^ node_id) >> o) == '0));
      end
    end
  endgenerate

  always_comb begin
    in_rdy = '0;
    for (int p = 0; p < NP; p++) begin
      for (int q = 0; q < NP; q++) begin
        in_rdy[q] = in_rdy[q] | gnt[p][q];
      end
    end
  end

  // R2
  eject_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> (ej_data[DIM-1:0] == node_id));
endmodule

// File: tb/tb_hcube_router.sv
module tb_hcube_router;
  localparam int DIM = 3;
  localparam int NN  = 8;
  localparam int PW  = 8;
  localparam int KW  = PW + DIM;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n;

  logic [DIM-1:0]    lo_v [NN];
  logic [DIM-1:0]    lo_r [NN];
  logic [DIM-1:0]    li_v [NN];
  logic [DIM-1:0]    li_r [NN];
  logic [DIM*KW-1:0] lo_d [NN];
  logic [DIM*KW-1:0] li_d [NN];
  logic              inj_v [NN];
  logic              inj_r [NN];
  logic              ej_v  [NN];
  logic              ej_r  [NN];
  logic [KW-1:0]     inj_d [NN];
  logic [KW-1:0]     ej_d  [NN];

  genvar n, d;
  generate
    for (n = 0; n < NN; n++) begin : g_node
      hcube_router #(.DIM(DIM), .PAY_W(PW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .node_id       (DIM'(n)),
        .inj_valid     (inj_v[n]),
        .inj_ready     (inj_r[n]),
        .inj_data      (inj_d[n]),
        .lnk_in_valid  (li_v[n]),
        .lnk_in_ready  (li_r[n]),
        .lnk_in_data   (li_d[n]),
        .lnk_out_valid (lo_v[n]),
        .lnk_out_ready (lo_r[n]),
        .lnk_out_data  (lo_d[n]),
        .ej_valid      (ej_v[n]),
        .ej_ready      (ej_r[n]),
        .ej_data       (ej_d[n])
      );
      for (d = 0; d < DIM; d++) begin : g_wire
        assign li_v[n][d]            = lo_v[n ^ (1 << d)][d];
        assign lo_r[n][d]            = li_r[n ^ (1 << d)][d];
        assign li_d[n][d*KW +: KW]   = lo_d[n ^ (1 << d)][d*KW +: KW];
      end
    end
  endgenerate

  int nchk = 0;
  int nfail = 0;
  int hops [64];
  int delivered [64];
  logic [PW-1:0] sent [64];
  int mid_cnt, mid_node;
  int watch = -1;
  int elog_n = 0;
  logic [PW-1:0] elog [16];

  function automatic int msb(input int v);
    int r;
    r = -1;
    for (int b = 0; b < 32; b++) if (v[b]) r = b;
    return r;
  endfunction

  function automatic int popc(input int v);
    int c;
    c = 0;
    for (int b = 0; b < 32; b++) if (v[b]) c++;
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Port monitor: every link hop and every ejection, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      #5;
      for (int s = 0; s < NN; s++) begin
        for (int k = 0; k < DIM; k++) begin
          if (lo_v[s][k] && lo_r[s][k]) begin
            logic [KW-1:0] pk;
            int dst, pid, nxt;
            pk  = lo_d[s][k*KW +: KW];
            dst = int'(pk[DIM-1:0]);
            pid = int'(pk[DIM+5:DIM]);
            chk(msb(s ^ dst) == k, "R3 hop dimension", k, msb(s ^ dst));
            hops[pid]++;
            nxt = s ^ (1 << k);
            if (pid == 5 && nxt != dst) begin
              mid_cnt++;
              mid_node = nxt;
            end
          end
        end
        if (ej_v[s] && ej_r[s]) begin
          logic [KW-1:0] pk;
          int dst, pid;
          pk  = ej_d[s];
          dst = int'(pk[DIM-1:0]);
          pid = int'(pk[DIM+5:DIM]);
          chk(dst == s, "R2 eject node", s, dst);
          chk(hops[pid] == popc((pid >> 3) ^ (pid & 7)), "R4 hop count",
              hops[pid], popc((pid >> 3) ^ (pid & 7)));
          chk(pk[KW-1:DIM] == sent[pid], "R9 payload",
              int'(pk[KW-1:DIM]), int'(sent[pid]));
          delivered[pid]++;
          if (s == watch && elog_n < 16) begin
            elog[elog_n] = pk[KW-1:DIM];
            elog_n++;
          end
        end
      end
    end
  end

  task automatic send(input int s, input int dd, input int tag);
    logic [PW-1:0] p;
    bit ok;
    p = {tag[1:0], 3'(s), 3'(dd)};
    sent[s*8 + dd] = p;
    @(negedge clk);
    inj_v[s] = 1'b1;
    inj_d[s] = {p, 3'(dd)};
    do begin
      #5 ok = inj_r[s];
      @(negedge clk);
    end while (!ok);
    inj_v[s] = 1'b0;
  endtask

  task automatic wait_pid(input int pid);
    int c;
    c = 0;
    while (delivered[pid] == 0 && c < 200) begin
      @(negedge clk);
      c++;
    end
    @(negedge clk);
  endtask

  task automatic clear_log();
    for (int p = 0; p < 64; p++) begin
      hops[p] = 0;
      delivered[p] = 0;
    end
    elog_n = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [PW-1:0] held;
    for (int s = 0; s < NN; s++) begin
      inj_v[s] = 1'b0;
      inj_d[s] = '0;
      ej_r[s]  = 1'b1;
    end
    clear_log();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    // R1: idle after reset
    for (int s = 0; s < NN; s++) begin
      chk(lo_v[s] == '0, "R1 link valid", int'(lo_v[s]), 0);
      chk(ej_v[s] == 1'b0, "R1 eject valid", int'(ej_v[s]), 0);
      chk(inj_r[s] == 1'b0, "R1 inject ready", int'(inj_r[s]), 0);
    end

    // R2 R3 R4 R5 R9: every pair alone
    for (int s = 0; s < NN; s++) begin
      for (int t = 0; t < NN; t++) begin
        clear_log();
        mid_cnt = 0;
        mid_node = -1;
        send(s, t, 1);
        wait_pid(s*8 + t);
        chk(delivered[s*8 + t] == 1, "R4 delivered once", delivered[s*8 + t], 1);
        if (s == 0 && t == 5) begin
          chk(mid_cnt == 1, "R5 intermediate count", mid_cnt, 1);
          chk(mid_node == 4, "R5 intermediate node", mid_node, 4);
        end
      end
    end

    // R6 R7: stalled ejection at node 3
    clear_log();
    watch = 3;
    ej_r[3] = 1'b0;
    send(3, 3, 1);
    @(negedge clk);
    #5;
    chk(ej_v[3] == 1'b1, "R6 eject valid under stall", int'(ej_v[3]), 1);
    held = ej_d[3][KW-1:DIM];
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      #5;
      chk(ej_v[3] == 1'b1, "R6 valid held", int'(ej_v[3]), 1);
      chk(ej_d[3][KW-1:DIM] == held, "R6 data held",
          int'(ej_d[3][KW-1:DIM]), int'(held));
    end
    fork
      send(2, 3, 2);
    join_none
    repeat (4) @(negedge clk);
    #5;
    chk(li_r[3][0] == 1'b0, "R7 input ready low while slot full", int'(li_r[3][0]), 0);
    chk(lo_v[2][0] == 1'b1, "R8 waiting packet kept", int'(lo_v[2][0]), 1);
    chk(lo_d[2][DIM +: PW] == sent[19], "R8 waiting data kept",
        int'(lo_d[2][DIM +: PW]), int'(sent[19]));
    @(negedge clk);
    ej_r[3] = 1'b1;
    wait_pid(19);
    chk(elog_n == 2, "R6 both delivered", elog_n, 2);
    chk(elog[0] == sent[27], "R6 first out", int'(elog[0]), int'(sent[27]));
    chk(elog[1] == sent[19], "R6 second out", int'(elog[1]), int'(sent[19]));

    // R8: round-robin at node 0 ejection, pointer left on link 1
    clear_log();
    watch = 0;
    ej_r[0] = 1'b0;
    send(2, 0, 1);
    repeat (4) @(negedge clk);
    fork
      send(1, 0, 1);
      send(0, 0, 1);
    join_none
    repeat (4) @(negedge clk);
    ej_r[0] = 1'b1;
    wait_pid(8);
    wait_pid(0);
    chk(elog_n == 3, "R8 count", elog_n, 3);
    chk(elog[0] == sent[16], "R8 first grant", int'(elog[0]), int'(sent[16]));
    chk(elog[1] == sent[0], "R8 local after link1", int'(elog[1]), int'(sent[0]));
    chk(elog[2] == sent[8], "R8 link0 last", int'(elog[2]), int'(sent[8]));
    watch = -1;

    // R10: all-to-all burst
    clear_log();
    for (int s = 0; s < NN; s++) begin
      automatic int ss = s;
      fork
        begin
          for (int j = 0; j < NN; j++) send(ss, ss ^ j, 3);
        end
      join_none
    end
    wait fork;
    begin
      int tot, c;
      c = 0;
      tot = 0;
      while (tot < 64 && c < 2000) begin
        @(negedge clk);
        tot = 0;
        for (int p = 0; p < 64; p++) tot += (delivered[p] != 0) ? 1 : 0;
        c++;
      end
    end
    repeat (2) @(negedge clk);
    for (int p = 0; p < 64; p++) begin
      chk(delivered[p] == 1, "R10 delivered exactly once", delivered[p], 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule